// File: doc/BRIEF.md
# Audio Function Power State Controller

This block sets the power state of an audio function group. A decoded request strobe carries one of four target states, D0 (fully active) to D3 (deepest retained state). From the state currently in force the block drives the enable lines for the analog sub-functions: one enable per converter, one shared enable for the mixer and port functions, and enables for the port amplifiers and the voltage reference. A low-power flag tells the amplifiers and the reference when to run in their reduced mode.

The reference voltage is never switched abruptly. An up/down level counter moves it one step at a time toward its goal. The reported state changes only when the reference has reached its goal, so a resume from D3 becomes visible once the ramp is complete. A request that arrives while a transition is still running is held and applied afterwards. A separate shutdown request turns the reference off completely, but only under a guarded ordering. An asynchronous power-loss input clears the reference level at once.

Top module: `afg_power_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `cur_state` is 3 (D3), `ref_level` is 0, every converter enable and `mix_port_en` are 0, `amp_en` and `ref_en` are 1, and `ref_lowpwr` is 1.
- R2: With `cur_state` 0 (D0) and `ref_level` at full scale, bit i of `conv_en` equals bit i of `node_d0`, where a 1 means converter i has its own node set to D0. `mix_port_en` is 1 and `ref_lowpwr` is 0.
- R3: With `cur_state` 1 (D1), `conv_en` is all zero and `mix_port_en` is 1 once the reference is at full scale.
- R4: With `cur_state` 2 (D2), `conv_en` and `mix_port_en` are 0, `amp_en` and `ref_en` are 1, and `ref_lowpwr` is 0.
- R5: With `cur_state` 3 (D3), `conv_en` and `mix_port_en` are 0 and `ref_lowpwr` is 1.
- R6: The state encoding is 0..3 for D0..D3. A request accepted at a clock edge moves `cur_state` to the requested value at the first later edge at which `ref_level` equals its goal. The goal is full scale, or 0 while the reference is shut down.
- R7: A request that arrives while a transition is in progress is latched. It becomes the new target in the cycle after the transition completes, and a later request overwrites an earlier one that is still pending.
- R8: `ref_off_req` takes effect only when no transition or pending request exists, `cur_state` is D3 and every bit of `port_pd` is 1. `amp_en` and `ref_en` then fall to 0 and the level ramps down to 0. In any other case the request is ignored. An accepted request for D0, D1 or D2 ends the shutdown.
- R9: Without power loss, `ref_level` moves by exactly one step after every STEP_DIV consecutive cycles spent away from its goal. It never changes by more than one step between edges.
- R10: While `pwr_lost` is high, `ref_level` is 0, and it is cleared asynchronously without waiting for a clock edge.
- R11: `mix_port_en` and `conv_en` are asserted only while `ref_level` is at full scale. They therefore fall before any ramp-down and rise only after a ramp-up completes.
- R12: A resume requested from D3 reaches D0 within RESUME_CYCLES cycles, even when it starts from a fully shut-down reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_lost | input | 1 | Asynchronous power-loss indication, forces the reference level to zero |
| req_valid | input | 1 | Single-cycle strobe carrying a state request |
| req_state | input | 2 | Requested state, 0..3 for D0..D3 |
| ref_off_req | input | 1 | Request to shut the reference down |
| port_pd | input | NUM_PORTS | Port power-down bits, 1 = port powered down |
| node_d0 | input | NUM_CONV | Per-converter node-level D0 indication |
| cur_state | output | 2 | State currently in force |
| conv_en | output | NUM_CONV | Converter enables |
| mix_port_en | output | 1 | Mixer and port function enable |
| amp_en | output | 1 | Port amplifier enable |
| ref_en | output | 1 | Voltage reference enable |
| ref_lowpwr | output | 1 | Low-power mode flag for amplifiers and reference |
| ref_level | output | LVL_W | Ramped reference level |

## Verification
The assertions assume that `pwr_lost` stays high across at least one rising clock edge once it rises. Without that, an asynchronous clear could fall between two samples and look like a multi-step jump. The resume deadline check assumes that no other request and no power loss interrupts a pending D3-to-D0 resume. The stimulus keeps to these limits: it holds power loss for several cycles, it issues each resume on its own, and it sends only single-cycle request strobes driven on the falling edge.

// File: rtl/afg_power_ctrl.sv
module afg_power_ctrl #(
  parameter int NUM_CONV      = 4,
  parameter int NUM_PORTS     = 6,
  parameter int LVL_W         = 8,
  parameter int STEP_DIV      = 900,
  parameter int RESUME_CYCLES = 240000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_lost,
  input  logic                 req_valid,
  input  logic [1:0]           req_state,
  input  logic                 ref_off_req,
  input  logic [NUM_PORTS-1:0] port_pd,
  input  logic [NUM_CONV-1:0]  node_d0,
  output logic [1:0]           cur_state,
  output logic [NUM_CONV-1:0]  conv_en,
  output logic                 mix_port_en,
  output logic                 amp_en,
  output logic                 ref_en,
  output logic                 ref_lowpwr,
  output logic [LVL_W-1:0]     ref_level
);
  localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_DIV - 1);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;
  localparam logic [1:0] ST_D0 = 2'd0;
  localparam logic [1:0] ST_D1 = 2'd1;
  localparam logic [1:0] ST_D3 = 2'd3;

  if ((2 ** LVL_W) * STEP_DIV + 4 > RESUME_CYCLES) begin : g_budget
    $error("reference ramp does not fit the resume budget");
  end

  logic [1:0]       tgt_q, pend_q;
  logic             pend_v_q, shut_q;
  logic [DIV_W-1:0] div_q;
  logic [LVL_W-1:0] lvl_q;

  wire busy     = (cur_state != tgt_q);
  wire [LVL_W-1:0] goal = shut_q ? '0 : LVL_MAX;
  wire at_goal  = (lvl_q == goal);
  wire full     = (lvl_q == LVL_MAX);
  wire shut_ok  = !busy && !req_valid && !pend_v_q && ref_off_req
                  && (cur_state == ST_D3) && (&port_pd);

  always_ff @(posedge clk or negedge rst_n or posedge pwr_lost) begin
    if (!rst_n) begin
      lvl_q <= '0;
      div_q <= '0;
    end else if (pwr_lost) begin
      lvl_q <= '0;
      div_q <= '0;
    end else if (at_goal) begin
      div_q <= '0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      lvl_q <= (lvl_q < goal) ? lvl_q + 1'b1 : lvl_q - 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_state <= ST_D3;
      tgt_q     <= ST_D3;
      pend_q    <= ST_D3;
      pend_v_q  <= 1'b0;
      shut_q    <= 1'b0;
    end else begin
      if (busy && at_goal) cur_state <= tgt_q;
      if (!busy) begin
        if (req_valid) begin
          tgt_q    <= req_state;
          pend_v_q <= 1'b0;
          if (req_state != ST_D3) shut_q <= 1'b0;
        end else if (pend_v_q) begin
          tgt_q    <= pend_q;
          pend_v_q <= 1'b0;
          if (pend_q != ST_D3) shut_q <= 1'b0;
        end else if (shut_ok) begin
          shut_q <= 1'b1;
        end
      end else if (req_valid) begin
        pend_q   <= req_state;
        pend_v_q <= 1'b1;
      end
    end
  end

  assign conv_en     = (cur_state == ST_D0 && full) ? node_d0 : '0;
  assign mix_port_en = (cur_state == ST_D0 || cur_state == ST_D1) && full;
  assign amp_en      = !shut_q;
  assign ref_en      = !shut_q;
  assign ref_lowpwr  = (cur_state == ST_D3);
  assign ref_level   = lvl_q;
endmodule

// File: rtl/afg_power_ctrl_chk.sv
module afg_power_ctrl_chk #(
  parameter int NUM_CONV      = 4,
  parameter int NUM_PORTS     = 6,
  parameter int LVL_W         = 8,
  parameter int RESUME_CYCLES = 240000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pwr_lost,
  input logic                 req_valid,
  input logic [1:0]           req_state,
  input logic [NUM_PORTS-1:0] port_pd,
  input logic [1:0]           cur_state,
  input logic [NUM_CONV-1:0]  conv_en,
  input logic                 mix_port_en,
  input logic                 ref_en,
  input logic                 ref_lowpwr,
  input logic [LVL_W-1:0]     ref_level
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic        res_act;
  logic [31:0] res_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_act <= 1'b0;
      res_cnt <= '0;
    end else if (req_valid && req_state == 2'd0 && cur_state == 2'd3) begin
      res_act <= 1'b1;
      res_cnt <= '0;
    end else if (cur_state == 2'd0 || (req_valid && req_state != 2'd0) || pwr_lost) begin
      res_act <= 1'b0;
      res_cnt <= '0;
    end else if (res_act) begin
      res_cnt <= res_cnt + 1;
    end
  end

  // R12
  resume_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_act |-> res_cnt < RESUME_CYCLES);

  // R9
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_lost)
    (ref_level == $past(ref_level)) || (ref_level == $past(ref_level) + 1'b1)
    || (ref_level == $past(ref_level) - 1'b1));

  // R10
  loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_lost |-> ref_level == '0);

  // R11
  func_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mix_port_en) || (|conv_en)) |-> ref_level == LVL_MAX);

  // R8
  shut_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_en) |-> ($past(cur_state) == 2'd3) && (&$past(port_pd)));

  // R5
  d3_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 2'd3) |-> (conv_en == '0) && !mix_port_en && ref_lowpwr);
endmodule

bind afg_power_ctrl afg_power_ctrl_chk #(
  .NUM_CONV(NUM_CONV), .NUM_PORTS(NUM_PORTS), .LVL_W(LVL_W), .RESUME_CYCLES(RESUME_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_lost(pwr_lost), .req_valid(req_valid),
  .req_state(req_state), .port_pd(port_pd), .cur_state(cur_state),
  .conv_en(conv_en), .mix_port_en(mix_port_en), .ref_en(ref_en),
  .ref_lowpwr(ref_lowpwr), .ref_level(ref_level)
);

// File: tb/afg_power_ctrl_tb_top.sv
`timescale 1ns/1ps
module afg_power_ctrl_tb_top;
  localparam int NC = 4, NP = 6, LW = 8, SD = 2, RB = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_lost = 1'b0, req_valid = 1'b0, ref_off_req = 1'b0;
  logic [1:0] req_state = 2'd0;
  logic [NP-1:0] port_pd = '0;
  logic [NC-1:0] node_d0 = '0;
  logic [1:0] cur_state;
  logic [NC-1:0] conv_en;
  logic mix_port_en, amp_en, ref_en, ref_lowpwr;
  logic [LW-1:0] ref_level;

  always #2 clk = ~clk;

  afg_power_ctrl #(.NUM_CONV(NC), .NUM_PORTS(NP), .LVL_W(LW), .STEP_DIV(SD), .RESUME_CYCLES(RB)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_lost(pwr_lost), .req_valid(req_valid),
    .req_state(req_state), .ref_off_req(ref_off_req), .port_pd(port_pd),
    .node_d0(node_d0), .cur_state(cur_state), .conv_en(conv_en),
    .mix_port_en(mix_port_en), .amp_en(amp_en), .ref_en(ref_en),
    .ref_lowpwr(ref_lowpwr), .ref_level(ref_level));

  int tests = 0, fails = 0;

  // behavioural reference model
  int m_cur, m_tgt, m_pend, m_lvl, m_div;
  bit m_pv, m_shut;
  always @(posedge clk) begin
    int goal, ncur;
    if (!rst_n) begin
      m_cur = 3; m_tgt = 3; m_pend = 3; m_pv = 0; m_shut = 0; m_lvl = 0; m_div = 0;
    end else begin
      goal = m_shut ? 0 : 255;
      ncur = (m_cur != m_tgt && m_lvl == goal) ? m_tgt : m_cur;
      if (pwr_lost) begin m_lvl = 0; m_div = 0; end
      else if (m_lvl == goal) m_div = 0;
      else if (m_div == SD - 1) begin m_div = 0; m_lvl += (m_lvl < goal) ? 1 : -1; end
      else m_div++;
      if (m_cur == m_tgt) begin
        if (req_valid) begin m_tgt = req_state; m_pv = 0; if (req_state != 3) m_shut = 0; end
        else if (m_pv) begin m_tgt = m_pend; m_pv = 0; if (m_pend != 3) m_shut = 0; end
        else if (ref_off_req && m_cur == 3 && &port_pd) m_shut = 1;
      end else if (req_valid) begin m_pend = req_state; m_pv = 1; end
      m_cur = ncur;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit full;
    int e_conv, e_mix;
    full = (m_lvl == 255);
    e_conv = (m_cur == 0 && full) ? int'(node_d0) : 0;
    e_mix = ((m_cur <= 1) && full) ? 1 : 0;
    check(int'(cur_state) == m_cur, "R6", "cur_state", cur_state, m_cur);
    check(int'(ref_level) == m_lvl, "R9", "ref_level", ref_level, m_lvl);
    check(int'(conv_en) == e_conv, "R2", "conv_en", conv_en, e_conv);
    check(int'(mix_port_en) == e_mix, "R3", "mix_port_en", mix_port_en, e_mix);
    check(amp_en == !m_shut && ref_en == !m_shut, "R8", "amp/ref_en", ref_en, !m_shut);
    check(ref_lowpwr == (m_cur == 3), "R5", "ref_lowpwr", ref_lowpwr, m_cur == 3);
    check(!(mix_port_en || |conv_en) || ref_level == 255, "R11", "level under enables", ref_level, 255);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic request(input logic [1:0] s);
    req_state = s; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
  endtask

  task automatic wait_state(input int s, input int lim, output int n);
    n = 0;
    while (int'(cur_state) != s && n < lim) begin step(); n++; end
  endtask

  initial begin
    int n;
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(cur_state == 2'd3 && ref_level == 0 && conv_en == 0 && !mix_port_en
          && amp_en && ref_en && ref_lowpwr, "R1", "reset outputs", cur_state, 3);
    rst_n = 1'b1;
    step();
    check(cur_state == 2'd3 && ref_level == 0, "R1", "after reset", ref_level, 0);
    node_d0 = 4'b1010;
    // R7: D0 requested during ramp, then D1 arrives while busy, then D2 overwrites it
    request(2'd0);
    repeat (5) step();
    request(2'd1);
    repeat (5) step();
    request(2'd2);
    wait_state(0, 700, n);
    check(cur_state == 2'd0, "R6", "reached D0 after ramp", cur_state, 0);
    step(); step();
    check(cur_state == 2'd2, "R7", "pending newest applied", cur_state, 2);
    // R4
    check(conv_en == 0 && !mix_port_en && amp_en && ref_en && !ref_lowpwr, "R4", "D2 enables", mix_port_en, 0);
    request(2'd1); step();
    check(cur_state == 2'd1 && conv_en == 0 && mix_port_en, "R3", "D1 enables", mix_port_en, 1);
    request(2'd0); step();
    check(conv_en == 4'b1010 && mix_port_en && !ref_lowpwr, "R2", "D0 converter mask", conv_en, 4'b1010);
    node_d0 = 4'b0111; step();
    check(conv_en == 4'b0111, "R2", "D0 converter mask 2", conv_en, 4'b0111);
    // R8 ignored outside D3
    port_pd = '1; ref_off_req = 1'b1; step(); ref_off_req = 1'b0; step();
    check(ref_en && ref_level == 255, "R8", "shutdown ignored in D0", ref_en, 1);
    request(2'd3); step();
    check(cur_state == 2'd3 && conv_en == 0 && !mix_port_en && ref_lowpwr, "R5", "D3 enables", cur_state, 3);
    // R8 ignored with one port still up
    port_pd = 6'b111011; ref_off_req = 1'b1; step(); ref_off_req = 1'b0; step();
    check(ref_en && amp_en && ref_level == 255, "R8", "shutdown ignored, port up", ref_en, 1);
    port_pd = '1; ref_off_req = 1'b1; step(); ref_off_req = 1'b0; step();
    check(!ref_en && !amp_en, "R8", "shutdown accepted", ref_en, 0);
    // R9: one step per SD cycles
    repeat (2 * SD) step();
    check(ref_level == 255 - 2, "R9", "ramp down rate", ref_level, 253);
    n = 0;
    while (ref_level != 0 && n < 700) begin step(); n++; end
    check(ref_level == 0, "R9", "ramp reached zero", ref_level, 0);
    // R12 resume from full shutdown
    request(2'd0);
    wait_state(0, RB + 50, n);
    check(cur_state == 2'd0 && n + 1 <= RB, "R12", "resume cycles", n + 1, RB);
    check(ref_en && amp_en && mix_port_en, "R11", "enables after ramp", mix_port_en, 1);
    // R10 asynchronous clear
    pwr_lost = 1'b1;
    #1;
    check(ref_level == 0, "R10", "async clear", ref_level, 0);
    check(conv_en == 0 && !mix_port_en, "R11", "enables drop with level", mix_port_en, 0);
    repeat (4) step();
    check(ref_level == 0, "R10", "held at zero", ref_level, 0);
    pwr_lost = 1'b0;
    n = 0;
    while (ref_level != 255 && n < 700) begin step(); n++; end
    check(mix_port_en && ref_level == 255, "R11", "re-enable at full scale", ref_level, 255);
    request(2'd2); step();
    check(cur_state == 2'd2, "R6", "idle transition one edge", cur_state, 2);
    repeat (5) step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule